// File: doc/BRIEF.md
# Per-Channel Window Sparsifier

This block is a streaming filter placed between a readout sequencer and the FIFO that buffers words for the host-bus side. Each incoming word carries a sample value, a channel index and a geographic slot number. The slot and channel together select one entry in each of three lookup tables: a lower bound, an upper bound and a replacement identifier. A data word whose value lies inside its entry's inclusive window is forwarded with its slot and channel bits replaced by the identifier. Any other data word is discarded. Header words skip the window test. A configuration pin decides whether they are passed through unchanged or removed.

The tables are filled through a plain write port: a strobe, a two-bit table select, an entry address and a 16-bit value. Both stream edges use valid/ready. On the input, a word is taken on a clock edge where `in_valid` and `in_ready` are both high. On the output, a word leaves on a clock edge where `out_valid` and `out_ready` are both high. `out_ready` is the FIFO's not-full flag. While `out_valid` is high and `out_ready` is low, the output word is held unchanged and the stall backs up into `in_ready`. A discarded word never waits for `out_ready`. The `idle` pin tells the sequencer that no word remains inside the block, which it uses to decide that the pipeline has drained.

Top module: `pedestal_sparsifier`

## Requirements
- R1: During and directly after reset, `idle` is 1, `out_valid` is 0 and `in_ready` is 1.
- R2: Input word layout: bits [15:0] are the value, bits [16+CH_W-1:16] are the channel, the SLOT_W bits directly above the channel are the slot, and bit 31 set marks a header. The table entry address is {slot, channel}, which is bits [16+CH_W+SLOT_W-1:16].
- R3: A data word (bit 31 clear) is forwarded only when lower <= value <= upper, compared unsigned. Otherwise it is discarded. Each input word produces at most one output word, and output order follows input order.
- R4: A forwarded data word is output as {identifier[15:0], value[15:0]}.
- R5: A header word is forwarded unchanged when `cfg_strip_hdr` is 0 and discarded when it is 1, whatever the table contents.
- R6: A word taken at clock edge n appears on `out_valid` and `out_data` after edge n+1, and not after edge n. With `out_ready` held high, `in_ready` never drops, so one word is taken per clock.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` stay unchanged on the next cycle. When both internal stages are occupied and the output is stalled, `in_ready` is 0. No word is lost or duplicated.
- R8: `idle` is 1 exactly when neither pipeline stage holds a word.
- R9: A write with `tbl_we`=1 stores `tbl_wdata` at `tbl_addr` in the table chosen by `tbl_sel`, where 0 selects the lower bound, 1 the upper bound, 2 the identifier, and 3 changes no table. A word taken on the same edge as a write to its own entry uses the entry's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_strip_hdr | input | 1 | 1 removes header words from the output |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Table select: 0 lower, 1 upper, 2 identifier, 3 none |
| tbl_addr | input | CH_W+SLOT_W | Table entry address |
| tbl_wdata | input | 16 | Table write value |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 32 | Input word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | FIFO not full |
| out_data | output | 32 | Output word |
| idle | output | 1 | No word held in the pipeline |

## Verification
Two pairs of events can land on the same clock edge. In the first, a table write and the lookup of that same entry coincide. The bench raises the write strobe on the cycle a word addressed to that entry is taken, expects the old identifier on that word, and expects the new identifier on an identical word sent afterwards. In the second, an output stall and a new input word coincide. The bench drives `out_ready` from a pseudo-random sequence while it streams a sweep over every table entry, with values on and next to each bound. It requires each held output word to stay stable and the output stream to match an arithmetic model word for word, with no gaps and no repeats.

// File: rtl/sparsifier_pkg.sv
package sparsifier_pkg;
  localparam int NUM_TABLES = 3;

  typedef enum logic [1:0] {
    SEL_LOWER = 2'd0,
    SEL_UPPER = 2'd1,
    SEL_IDENT = 2'd2,
    SEL_NONE  = 2'd3
  } tbl_sel_e;

  function automatic tbl_sel_e table_kind(input int idx);
    return tbl_sel_e'(idx[1:0]);
  endfunction
endpackage

// File: rtl/lut_bank.sv
module lut_bank #(
  parameter int AW = 12,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  // Read-first: the read of an entry written on the same edge returns old data.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rd_data <= mem[raddr];
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rd_data)); // R7
endmodule

// File: rtl/window_judge.sv
module window_judge #(
  parameter int DATA_W = 32,
  parameter int VAL_W  = 16,
  parameter int TW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [DATA_W-1:0] word,
  input  logic [TW-1:0]     lower,
  input  logic [TW-1:0]     upper,
  input  logic [TW-1:0]     ident,
  input  logic              strip_hdr,
  output logic              keep,
  output logic [DATA_W-1:0] word_out
);
  logic             is_hdr;
  logic [VAL_W-1:0] value;
  logic             in_window;

  always_comb begin
    is_hdr    = word[DATA_W-1];
    value     = word[VAL_W-1:0];
    in_window = (TW'(value) >= lower) && (TW'(value) <= upper);
    keep      = is_hdr ? !strip_hdr : in_window;
    word_out  = is_hdr ? word : DATA_W'({ident, value});
  end

  AST_HDR_STRIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && strip_hdr && word[DATA_W-1]) |-> !keep); // R5
endmodule

// File: rtl/pedestal_sparsifier.sv
module pedestal_sparsifier
  import sparsifier_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VAL_W  = 16,
  parameter int CH_W   = 7,
  parameter int SLOT_W = 5,
  parameter int TW     = 16,
  localparam int IDX_W = CH_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_strip_hdr,
  input  logic              tbl_we,
  input  logic [1:0]        tbl_sel,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [TW-1:0]     tbl_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              idle
);
  logic              in_fire;
  logic              adv2;
  logic [IDX_W-1:0]  rd_idx;
  logic [TW-1:0]     tbl_q [NUM_TABLES];

  // Stage 1: word registered while the tables are read.
  logic              s1_valid;
  logic [DATA_W-1:0] s1_word;
  // Stage 2: word and its entry, judged combinationally.
  logic              s2_valid;
  logic [DATA_W-1:0] s2_word;
  logic [TW-1:0]     s2_lower, s2_upper, s2_ident;
  logic              s2_keep;
  logic [DATA_W-1:0] s2_out;

  assign rd_idx  = in_data[VAL_W +: IDX_W];
  assign in_fire = in_valid && in_ready;

  for (genvar g = 0; g < NUM_TABLES; g++) begin : g_tbl
    localparam tbl_sel_e KIND = table_kind(g);
    lut_bank #(.AW(IDX_W), .DW(TW)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (tbl_we && (tbl_sel_e'(tbl_sel) == KIND)),
      .waddr  (tbl_addr),
      .wdata  (tbl_wdata),
      .re     (in_fire),
      .raddr  (rd_idx),
      .rd_data(tbl_q[g])
    );
  end

  window_judge #(.DATA_W(DATA_W), .VAL_W(VAL_W), .TW(TW)) u_judge (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld      (s2_valid),
    .word     (s2_word),
    .lower    (s2_lower),
    .upper    (s2_upper),
    .ident    (s2_ident),
    .strip_hdr(cfg_strip_hdr),
    .keep     (s2_keep),
    .word_out (s2_out)
  );

  // A dropped word leaves stage 2 without waiting for the FIFO.
  assign adv2     = !s2_valid || !s2_keep || out_ready;
  assign in_ready = !s1_valid || adv2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_word  <= '0;
    end else if (in_ready) begin
      s1_valid <= in_valid;
      if (in_valid) s1_word <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_word  <= '0;
      s2_lower <= '0;
      s2_upper <= '0;
      s2_ident <= '0;
    end else if (adv2) begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_word  <= s1_word;
        s2_lower <= tbl_q[0];
        s2_upper <= tbl_q[1];
        s2_ident <= tbl_q[2];
      end
    end
  end

  assign out_valid = s2_valid && s2_keep;
  assign out_data  = s2_out;
  assign idle      = !s1_valid && !s2_valid;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!out_valid && in_ready)); // R8

  AST_FIRE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> !idle); // R8
endmodule

// File: tb/tb_pedestal_sparsifier.sv
module tb_pedestal_sparsifier;
  localparam int CLK_PERIOD = 10;
  localparam int CH_W = 3;
  localparam int SLOT_W = 2;
  localparam int IDX_W = CH_W + SLOT_W;
  localparam int N_ENT = 1 << IDX_W;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_strip_hdr = 0;
  logic tbl_we = 0;
  logic [1:0] tbl_sel = 0;
  logic [IDX_W-1:0] tbl_addr = 0;
  logic [15:0] tbl_wdata = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [31:0] in_data = 0;
  logic out_valid;
  logic out_ready;
  logic [31:0] out_data;
  logic idle;

  logic tog_en = 0;
  logic force_ready = 1;
  logic [15:0] lfsr = 16'hACE1;

  int errors = 0;
  int checks = 0;
  int stalls = 0;
  int wr_i = 0;
  int rd_i = 0;
  bit count_stalls = 0;
  bit done = 0;
  logic [31:0] exp_q [1024];
  string exp_tag [1024];
  logic [15:0] m_lo [N_ENT];
  logic [15:0] m_hi [N_ENT];
  logic [15:0] m_id [N_ENT];
  logic prev_stall = 0;
  logic [31:0] prev_data = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pedestal_sparsifier #(.CH_W(CH_W), .SLOT_W(SLOT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_strip_hdr(cfg_strip_hdr),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .idle(idle)
  );

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = tog_en ? lfsr[0] : force_ready;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Output monitor: ordered comparison and hold check.
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R7 hold", out_data, prev_data);
      if (out_valid && out_ready) begin
        if (rd_i < wr_i) chk(out_data == exp_q[rd_i], exp_tag[rd_i], out_data, exp_q[rd_i]);
        else chk(0, "R3 extra word", out_data, 32'h0);
        rd_i++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  function automatic logic [15:0] f_lo(input int a);
    return 16'(a * 3 + 10);
  endfunction
  function automatic logic [15:0] f_hi(input int a);
    return (a % 8 == 7) ? 16'(a * 3 + 9) : 16'(a * 3 + 30);
  endfunction
  function automatic logic [15:0] f_id(input int a);
    return 16'(16'h5000 + a * 37);
  endfunction

  function automatic logic [31:0] mk_word(input int a, input logic [15:0] v);
    logic [31:0] w;
    w = 32'h0;
    w[15:0] = v;
    w[16 +: IDX_W] = IDX_W'(a);
    return w;
  endfunction

  function automatic logic [31:0] mk_hdr(input int a);
    return 32'h8000_0000 | ((32'(a) * 32'h0013_579B + 32'h0246) & 32'h7FFF_FFFF);
  endfunction

  task automatic push_exp(input logic [31:0] w);
    int a;
    logic [15:0] v;
    a = int'(w[16 +: IDX_W]);
    v = w[15:0];
    if (w[31]) begin
      if (!cfg_strip_hdr) begin
        exp_q[wr_i] = w; exp_tag[wr_i] = "R5 header pass"; wr_i++;
      end
    end else if (v >= m_lo[a] && v <= m_hi[a]) begin
      exp_q[wr_i] = {m_id[a], v}; exp_tag[wr_i] = "R3/R4 kept word"; wr_i++;
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1;
    in_data = w;
    #1;
    if (!in_ready && count_stalls) stalls++;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    push_exp(w);
    @(posedge clk);
  endtask

  task automatic stop_in();
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wr_tbl(input logic [1:0] s, input int a, input logic [15:0] d);
    @(negedge clk);
    tbl_we = 1; tbl_sel = s; tbl_addr = IDX_W'(a); tbl_wdata = d;
    @(posedge clk);
    @(negedge clk);
    tbl_we = 0;
    if (s == 2'd0) m_lo[a] = d;
    if (s == 2'd1) m_hi[a] = d;
    if (s == 2'd2) m_id[a] = d;
  endtask

  task automatic drain();
    int n = 0;
    @(negedge clk);
    while (!idle && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic sweep(input bit with_hdr);
    for (int a = 0; a < N_ENT; a++) begin
      logic [15:0] lo, hi;
      lo = f_lo(a);
      hi = f_hi(a);
      if (with_hdr) send(mk_hdr(a));
      send(mk_word(a, lo - 16'd1));
      send(mk_word(a, lo));
      send(mk_word(a, lo + 16'd7));
      send(mk_word(a, hi));
      send(mk_word(a, hi + 16'd1));
      send(mk_word(a, 16'hFFFF));
    end
    stop_in();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", rd_i, wr_i);
    finish_run();
  end

  initial begin
    logic [31:0] w;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(idle == 1, "R1 idle", 32'(idle), 1);
    chk(out_valid == 0, "R1 out_valid", 32'(out_valid), 0);
    chk(in_ready == 1, "R1 in_ready", 32'(in_ready), 1);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(idle == 1 && out_valid == 0 && in_ready == 1, "R1 after release",
        {29'b0, idle, out_valid, in_ready}, 32'h5);

    // R9: load every entry of the three tables
    for (int a = 0; a < N_ENT; a++) begin
      wr_tbl(2'd0, a, f_lo(a));
      wr_tbl(2'd1, a, f_hi(a));
      wr_tbl(2'd2, a, f_id(a));
    end

    // R2 R3 R4 R6: full sweep with the output always ready
    count_stalls = 1;
    sweep(0);
    count_stalls = 0;
    drain();
    chk(stalls == 0, "R6 throughput stalls", stalls, 0);

    // R6: latency of one word
    @(negedge clk);
    w = mk_word(3, f_lo(3));
    in_valid = 1; in_data = w;
    push_exp(w);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    #1;
    chk(out_valid == 0, "R6 not after edge n", 32'(out_valid), 0);
    @(negedge clk);
    #1;
    chk(out_valid == 1 && out_data == {f_id(3), f_lo(3)}, "R6 after edge n+1", out_data, {f_id(3), f_lo(3)});
    drain();

    // R7 R8: stalled output fills both stages
    force_ready = 0;
    send(mk_word(4, f_lo(4)));
    send(mk_word(5, f_lo(5) + 16'd1));
    stop_in();
    #1;
    chk(in_ready == 0, "R7 in_ready low when full", 32'(in_ready), 0);
    chk(idle == 0, "R8 idle low when occupied", 32'(idle), 0);
    repeat (3) @(negedge clk);
    chk(out_valid == 1, "R7 output held", 32'(out_valid), 1);
    force_ready = 1;
    drain();
    chk(idle == 1, "R8 idle after drain", 32'(idle), 1);

    // R5 R7: headers passed, random back-pressure
    tog_en = 1;
    cfg_strip_hdr = 0;
    sweep(1);
    drain();
    // R5: headers stripped
    cfg_strip_hdr = 1;
    sweep(1);
    drain();
    tog_en = 0;
    force_ready = 1;
    drain();

    // R9: write coinciding with lookup of the same entry
    @(negedge clk);
    w = mk_word(6, f_lo(6));
    in_valid = 1; in_data = w;
    tbl_we = 1; tbl_sel = 2'd2; tbl_addr = IDX_W'(6); tbl_wdata = 16'h7777;
    #1;
    chk(in_ready == 1, "R9 ready at collision", 32'(in_ready), 1);
    push_exp(w);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; tbl_we = 0;
    m_id[6] = 16'h7777;
    send(w);
    stop_in();
    drain();
    // R9: select 3 changes no table
    wr_tbl(2'd3, 6, 16'hFFFF);
    send(w);
    send(mk_word(6, f_hi(6) + 16'd1));
    stop_in();
    drain();

    chk(rd_i == wr_i, "R3 output count", rd_i, wr_i);
    finish_run();
  end
endmodule